// File: doc/BRIEF.md
# Oldest-first multi-port dispatch scheduler

A unified reservation station for an out-of-order core. Two hardware threads draw on one common pool of entries, with no share set aside for either. Each cycle a group of up to `ALLOC_W` renamed operations may be written into free entries. Each operation carries a thread bit, an execution class, two source tags with their ready bits, and an opaque payload. A waiting source turns ready when its tag appears on one of the `N_WB` result-tag broadcast lanes.

Every cycle the block scans the ten dispatch ports in order from port 0 to port 9. Each port is given the oldest operation that is fully ready, that its class allows on that port, and that a lower-numbered port has not already taken. A granted entry leaves at the next clock edge. A per-thread flush removes all of one thread's entries in a single cycle and leaves the other thread's entries alone.

Top module: `sched_rs`

## Requirements
- R1: After reset no port reports a grant, and `alloc_ready_o` is high for any group of up to `ALLOC_W` operations.
- R2: A class code allows only these ports (port p is bit p of the grant outputs): 0 general integer {0,1,5,6}, 1 branch {0,6}, 2 divide/square-root {0}, 3 vector permute {5}, 4 load {2,3}, 5 store-address {7,8}, 6 store-data {4,9}, 7 FP multiply-add {0,1}.
- R3: An entry is never granted while either of its source-ready bits is clear. It stays held until both are set.
- R4: A valid broadcast lane whose tag equals a waiting source tag sets that source ready, so the entry can be granted in the next cycle. This also applies to an operation being allocated in the same cycle as the broadcast. Tags that do not match wake nothing.
- R5: Among the ready entries allowed on a port, the port is granted the one allocated earliest.
- R6: Ports choose in ascending number. An operation allowed on several ports is granted to at most one of them in a cycle. Each later port takes the oldest operation still left.
- R7: Up to `ALLOC_W` operations are accepted per cycle. Within a group, a lower slot index counts as older. An accepted operation can be granted in the cycle after it is written, and a granted entry is freed at the next edge.
- R8: When fewer entries are free than the number of valid slots in the group, `alloc_ready_o` is low and no slot of the group is written. A group that exactly fits is accepted.
- R9: While `flush_i[t]` is high, no entry of thread t is granted and no slot of thread t is written. At the edge, every entry of thread t is removed. Entries of the other thread are unaffected.
- R10: Either thread may occupy every entry.
- R11: All ten ports can grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | ALLOC_W | Valid bit for each allocation slot |
| alloc_tid_i | input | ALLOC_W | Thread of each slot |
| alloc_cls_i | input | ALLOC_W*3 | Execution class of each slot |
| alloc_src_tag_i | input | ALLOC_W*2*TAG_W | Two source tags per slot; source k of slot s sits at index 2s+k |
| alloc_src_rdy_i | input | ALLOC_W*2 | Ready bits of the source tags |
| alloc_pay_i | input | ALLOC_W*PAY_W | Payload of each slot |
| alloc_ready_o | output | 1 | The whole group fits and is accepted |
| wb_valid_i | input | N_WB | Broadcast lane valid bits |
| wb_tag_i | input | N_WB*TAG_W | Broadcast result tags |
| flush_i | input | 2 | Flush request for each thread |
| disp_valid_o | output | 10 | Grant on each port |
| disp_tid_o | output | 10 | Thread of the granted operation on each port |
| disp_pay_o | output | 10*PAY_W | Payload of the granted operation on each port |

## Verification
The bench builds the block with 32 entries, five allocation slots and four broadcast lanes. At that size, six full groups plus one pair fill the pool, so both the stall on a group that is one too large and the exact fit can be reached in a few cycles. Two five-wide groups that all wait on one tag are woken together, which loads all ten ports in a single cycle. The fourth broadcast lane is used to check the wakeup that happens in the same cycle as allocation.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_PORTS = 10;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 3'd0,
    CLS_BR   = 3'd1,
    CLS_DIV  = 3'd2,
    CLS_PERM = 3'd3,
    CLS_LD   = 3'd4,
    CLS_STA  = 3'd5,
    CLS_STD  = 3'd6,
    CLS_FMA  = 3'd7
  } op_cls_e;

  // bit p set: the class may issue on port p
  function automatic logic [NUM_PORTS-1:0] port_mask(input logic [CLS_W-1:0] c);
    case (op_cls_e'(c))
      CLS_INT:  port_mask = 10'h063;
      CLS_BR:   port_mask = 10'h041;
      CLS_DIV:  port_mask = 10'h001;
      CLS_PERM: port_mask = 10'h020;
      CLS_LD:   port_mask = 10'h00C;
      CLS_STA:  port_mask = 10'h180;
      CLS_STD:  port_mask = 10'h210;
      default:  port_mask = 10'h003;
    endcase
  endfunction
endpackage

// File: rtl/sched_alloc.sv
module sched_alloc #(
  parameter int N_ENT   = 48,
  parameter int ALLOC_W = 5
) (
  input  logic [N_ENT-1:0]                busy_i,
  input  logic [ALLOC_W-1:0]              req_i,
  output logic                            grant_o,
  output logic [ALLOC_W-1:0][N_ENT-1:0]   slot_oh_o
);
  localparam int CNT_W = $clog2(N_ENT + 1);

  logic [CNT_W-1:0] free_cnt;
  logic [CNT_W-1:0] need_cnt;
  logic [N_ENT-1:0] avail;
  logic             found;

  always_comb begin
    free_cnt = '0;
    for (int e = 0; e < N_ENT; e++) free_cnt = free_cnt + CNT_W'(!busy_i[e]);
    need_cnt = '0;
    for (int s = 0; s < ALLOC_W; s++) need_cnt = need_cnt + CNT_W'(req_i[s]);
  end

  assign grant_o = (free_cnt >= need_cnt);

  // each valid slot takes the lowest free entry left by the slots before it
  always_comb begin
    avail     = ~busy_i;
    slot_oh_o = '0;
    found     = 1'b0;
    for (int s = 0; s < ALLOC_W; s++) begin
      found = 1'b0;
      if (req_i[s]) begin
        for (int e = 0; e < N_ENT; e++) begin
          if (avail[e] && !found) begin
            slot_oh_o[s][e] = 1'b1;
            avail[e]        = 1'b0;
            found           = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sched_age.sv
module sched_age #(
  parameter int N_ENT   = 48,
  parameter int ALLOC_W = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ALLOC_W-1:0][N_ENT-1:0] new_oh_i,
  output logic [N_ENT-1:0][N_ENT-1:0]   older_o
);
  localparam int SLOT_W = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1;

  logic [N_ENT-1:0]             is_new;
  logic [N_ENT-1:0][SLOT_W-1:0] slot_of;
  logic [N_ENT-1:0][N_ENT-1:0]  older_q, older_d;

  always_comb begin
    is_new  = '0;
    slot_of = '0;
    for (int s = 0; s < ALLOC_W; s++)
      for (int e = 0; e < N_ENT; e++)
        if (new_oh_i[s][e]) begin
          is_new[e]  = 1'b1;
          slot_of[e] = SLOT_W'(s);
        end
  end

  // older[i][j]: entry i was allocated before entry j
  always_comb begin
    older_d = older_q;
    for (int i = 0; i < N_ENT; i++)
      for (int j = 0; j < N_ENT; j++) begin
        if (is_new[i] && is_new[j]) older_d[i][j] = (slot_of[i] < slot_of[j]);
        else if (is_new[i])         older_d[i][j] = 1'b0;
        else if (is_new[j])         older_d[i][j] = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) older_q <= '0;
    else         older_q <= older_d;
  end

  assign older_o = older_q;
endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
#(
  parameter int N_ENT = 48
) (
  input  logic [N_ENT-1:0]                 rdy_i,
  input  logic [N_ENT-1:0][NUM_PORTS-1:0]  elig_i,
  input  logic [N_ENT-1:0][N_ENT-1:0]      older_i,
  output logic [NUM_PORTS-1:0][N_ENT-1:0]  gnt_o
);
  logic [N_ENT-1:0] taken;
  logic [N_ENT-1:0] cand;
  logic             beaten;

  // ports claim in ascending order; an entry taken by one port is hidden from the rest
  always_comb begin
    taken  = '0;
    gnt_o  = '0;
    cand   = '0;
    beaten = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int e = 0; e < N_ENT; e++) cand[e] = rdy_i[e] & elig_i[e][p] & ~taken[e];
      for (int i = 0; i < N_ENT; i++) begin
        beaten = 1'b0;
        for (int j = 0; j < N_ENT; j++) beaten = beaten | (cand[j] & older_i[j][i]);
        gnt_o[p][i] = cand[i] & ~beaten;
      end
      taken = taken | gnt_o[p];
    end
  end
endmodule

// File: rtl/sched_rs.sv
module sched_rs
  import sched_pkg::*;
#(
  parameter int N_ENT   = 48,
  parameter int ALLOC_W = 5,
  parameter int N_WB    = 4,
  parameter int TAG_W   = 7,
  parameter int PAY_W   = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ALLOC_W-1:0]           alloc_valid_i,
  input  logic [ALLOC_W-1:0]           alloc_tid_i,
  input  logic [ALLOC_W*CLS_W-1:0]     alloc_cls_i,
  input  logic [ALLOC_W*2*TAG_W-1:0]   alloc_src_tag_i,
  input  logic [ALLOC_W*2-1:0]         alloc_src_rdy_i,
  input  logic [ALLOC_W*PAY_W-1:0]     alloc_pay_i,
  output logic                         alloc_ready_o,
  input  logic [N_WB-1:0]              wb_valid_i,
  input  logic [N_WB*TAG_W-1:0]        wb_tag_i,
  input  logic [1:0]                   flush_i,
  output logic [NUM_PORTS-1:0]         disp_valid_o,
  output logic [NUM_PORTS-1:0]         disp_tid_o,
  output logic [NUM_PORTS*PAY_W-1:0]   disp_pay_o
);
  logic [N_ENT-1:0]                   vld_q;
  logic [N_ENT-1:0]                   tid_q;
  logic [N_ENT-1:0][CLS_W-1:0]        cls_q;
  logic [N_ENT-1:0][1:0][TAG_W-1:0]   tag_q;
  logic [N_ENT-1:0][1:0]              rdy_q;
  logic [N_ENT-1:0][PAY_W-1:0]        pay_q;

  logic [ALLOC_W-1:0][N_ENT-1:0]      slot_oh, new_oh;
  logic [N_ENT-1:0]                   wr_en;
  logic [N_ENT-1:0]                   wr_tid;
  logic [N_ENT-1:0][CLS_W-1:0]        wr_cls;
  logic [N_ENT-1:0][1:0][TAG_W-1:0]   wr_tag;
  logic [N_ENT-1:0][1:0]              wr_rdy;
  logic [N_ENT-1:0][PAY_W-1:0]        wr_pay;

  logic [N_ENT-1:0][N_ENT-1:0]        older;
  logic [N_ENT-1:0][NUM_PORTS-1:0]    elig;
  logic [N_ENT-1:0]                   src_done, pick_rdy, issued;
  logic [NUM_PORTS-1:0][N_ENT-1:0]    gnt;

  function automatic logic tag_hit(input logic [TAG_W-1:0] t,
                                   input logic [N_WB-1:0] v,
                                   input logic [N_WB*TAG_W-1:0] tags);
    tag_hit = 1'b0;
    for (int w = 0; w < N_WB; w++)
      if (v[w] && tags[w*TAG_W +: TAG_W] == t) tag_hit = 1'b1;
  endfunction

  sched_alloc #(.N_ENT(N_ENT), .ALLOC_W(ALLOC_W)) u_alloc (
    .busy_i    (vld_q),
    .req_i     (alloc_valid_i),
    .grant_o   (alloc_ready_o),
    .slot_oh_o (slot_oh)
  );

  // flushed-thread slots are dropped
  always_comb begin
    for (int s = 0; s < ALLOC_W; s++)
      new_oh[s] = (alloc_valid_i[s] && alloc_ready_o && !flush_i[alloc_tid_i[s]])
                  ? slot_oh[s] : '0;
  end

  always_comb begin
    wr_en = '0; wr_tid = '0; wr_cls = '0; wr_tag = '0; wr_rdy = '0; wr_pay = '0;
    for (int s = 0; s < ALLOC_W; s++)
      for (int e = 0; e < N_ENT; e++)
        if (new_oh[s][e]) begin
          wr_en[e]  = 1'b1;
          wr_tid[e] = alloc_tid_i[s];
          wr_cls[e] = alloc_cls_i[s*CLS_W +: CLS_W];
          wr_pay[e] = alloc_pay_i[s*PAY_W +: PAY_W];
          for (int k = 0; k < 2; k++) begin
            wr_tag[e][k] = alloc_src_tag_i[(s*2+k)*TAG_W +: TAG_W];
            wr_rdy[e][k] = alloc_src_rdy_i[s*2+k] |
                           tag_hit(alloc_src_tag_i[(s*2+k)*TAG_W +: TAG_W], wb_valid_i, wb_tag_i);
          end
        end
  end

  sched_age #(.N_ENT(N_ENT), .ALLOC_W(ALLOC_W)) u_age (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .new_oh_i (new_oh),
    .older_o  (older)
  );

  always_comb begin
    for (int e = 0; e < N_ENT; e++) begin
      elig[e]     = port_mask(cls_q[e]);
      src_done[e] = vld_q[e] & rdy_q[e][0] & rdy_q[e][1];
      pick_rdy[e] = src_done[e] & ~flush_i[tid_q[e]];
    end
  end

  sched_pick #(.N_ENT(N_ENT)) u_pick (
    .rdy_i   (pick_rdy),
    .elig_i  (elig),
    .older_i (older),
    .gnt_o   (gnt)
  );

  always_comb begin
    issued = '0;
    for (int p = 0; p < NUM_PORTS; p++) issued = issued | gnt[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0; tid_q <= '0; cls_q <= '0; tag_q <= '0; rdy_q <= '0; pay_q <= '0;
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        if (wr_en[e]) begin
          vld_q[e] <= 1'b1;
          tid_q[e] <= wr_tid[e];
          cls_q[e] <= wr_cls[e];
          tag_q[e] <= wr_tag[e];
          rdy_q[e] <= wr_rdy[e];
          pay_q[e] <= wr_pay[e];
        end else begin
          if (issued[e] || flush_i[tid_q[e]]) vld_q[e] <= 1'b0;
          for (int k = 0; k < 2; k++)
            if (tag_hit(tag_q[e][k], wb_valid_i, wb_tag_i)) rdy_q[e][k] <= 1'b1;
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PAY_W-1:0] pay_sel;
    logic             tid_sel;
    logic [N_ENT-1:0] elig_col;
    always_comb begin
      pay_sel = '0;
      tid_sel = 1'b0;
      for (int e = 0; e < N_ENT; e++) begin
        elig_col[e] = elig[e][p];
        if (gnt[p][e]) begin
          pay_sel = pay_sel | pay_q[e];
          tid_sel = tid_sel | tid_q[e];
        end
      end
    end
    assign disp_valid_o[p]              = |gnt[p];
    assign disp_tid_o[p]                = tid_sel;
    assign disp_pay_o[p*PAY_W +: PAY_W] = pay_sel;

    p_port_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt[p] & ~elig_col) == '0);
    p_src_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt[p] & ~src_done) == '0);
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent_chk
    logic [NUM_PORTS-1:0] gnt_col;
    always_comb for (int p = 0; p < NUM_PORTS; p++) gnt_col[p] = gnt[p][e];
    p_one_port_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_col));
    p_no_write_on_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!vld_q[e] && !alloc_ready_o) |=> !vld_q[e]);
  end

  p_flush_t0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i[0] |=> ((vld_q & ~tid_q) == '0));
  p_flush_t1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i[1] |=> ((vld_q & tid_q) == '0));
endmodule

// File: tb/sim_sched_rs.sv
module sim_sched_rs;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENT = 32, ALLOC_W = 5, N_WB = 4, TAG_W = 7, PAY_W = 8, NP = 10;
  localparam logic [2:0] C_INT = 3'd0, C_DIV = 3'd2, C_PERM = 3'd3,
                         C_LD = 3'd4, C_STA = 3'd5, C_STD = 3'd6;

  logic clk = 1'b0, rst_ni;
  logic [ALLOC_W-1:0]         alloc_valid_i, alloc_tid_i;
  logic [ALLOC_W*3-1:0]       alloc_cls_i;
  logic [ALLOC_W*2*TAG_W-1:0] alloc_src_tag_i;
  logic [ALLOC_W*2-1:0]       alloc_src_rdy_i;
  logic [ALLOC_W*PAY_W-1:0]   alloc_pay_i;
  logic                       alloc_ready_o;
  logic [N_WB-1:0]            wb_valid_i;
  logic [N_WB*TAG_W-1:0]      wb_tag_i;
  logic [1:0]                 flush_i;
  logic [NP-1:0]              disp_valid_o, disp_tid_o;
  logic [NP*PAY_W-1:0]        disp_pay_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { int port; int pay; bit tid; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_rs #(.N_ENT(N_ENT), .ALLOC_W(ALLOC_W), .N_WB(N_WB), .TAG_W(TAG_W), .PAY_W(PAY_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .alloc_valid_i(alloc_valid_i), .alloc_tid_i(alloc_tid_i),
    .alloc_cls_i(alloc_cls_i), .alloc_src_tag_i(alloc_src_tag_i), .alloc_src_rdy_i(alloc_src_rdy_i),
    .alloc_pay_i(alloc_pay_i), .alloc_ready_o(alloc_ready_o), .wb_valid_i(wb_valid_i),
    .wb_tag_i(wb_tag_i), .flush_i(flush_i), .disp_valid_o(disp_valid_o),
    .disp_tid_o(disp_tid_o), .disp_pay_o(disp_pay_o));

  task automatic clear_in();
    alloc_valid_i = '0; alloc_tid_i = '0; alloc_cls_i = '0; alloc_src_tag_i = '0;
    alloc_src_rdy_i = '0; alloc_pay_i = '0; wb_valid_i = '0; wb_tag_i = '0; flush_i = '0;
  endtask

  task automatic put_op(input int s, input bit tid, input logic [2:0] cls,
                        input logic [TAG_W-1:0] t0, input bit r0,
                        input logic [TAG_W-1:0] t1, input bit r1, input logic [PAY_W-1:0] pay);
    alloc_valid_i[s] = 1'b1;
    alloc_tid_i[s] = tid;
    alloc_cls_i[s*3 +: 3] = cls;
    alloc_src_tag_i[(s*2)*TAG_W +: TAG_W] = t0;
    alloc_src_tag_i[(s*2+1)*TAG_W +: TAG_W] = t1;
    alloc_src_rdy_i[s*2] = r0;
    alloc_src_rdy_i[s*2+1] = r1;
    alloc_pay_i[s*PAY_W +: PAY_W] = pay;
  endtask

  task automatic bcast(input int lane, input logic [TAG_W-1:0] t);
    wb_valid_i[lane] = 1'b1;
    wb_tag_i[lane*TAG_W +: TAG_W] = t;
  endtask

  task automatic tick();
    @(posedge clk); #1; clear_in(); @(negedge clk);
  endtask

  task automatic expect_disp(input int p, input int pay, input bit tid);
    exp_t x;
    x.port = p; x.pay = pay; x.tid = tid;
    exp_q.push_back(x);
  endtask

  // monitor: pops every expected grant for this cycle and compares all ports
  task automatic check_disp(input string req);
    logic [NP-1:0] ev, et;
    int ep[NP];
    exp_t x;
    bit ok;
    ev = '0; et = '0;
    for (int p = 0; p < NP; p++) ep[p] = 0;
    while (exp_q.size() > 0) begin
      x = exp_q.pop_front();
      ev[x.port] = 1'b1; ep[x.port] = x.pay; et[x.port] = x.tid;
    end
    ok = 1; n_chk++;
    for (int p = 0; p < NP; p++) begin
      if (disp_valid_o[p] !== ev[p] ||
          (ev[p] && (int'(disp_pay_o[p*PAY_W +: PAY_W]) != ep[p] || disp_tid_o[p] !== et[p]))) begin
        ok = 0;
        $display("FAIL %s port%0d: actual v=%0b pay=%0d tid=%0b expected v=%0b pay=%0d tid=%0b",
                 req, p, disp_valid_o[p], disp_pay_o[p*PAY_W +: PAY_W], disp_tid_o[p],
                 ev[p], ep[p], et[p]);
      end
    end
    if (!ok) n_bad++;
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);

    // R1 reset state
    check_disp("R1 no grant after reset");
    alloc_valid_i = '1; #1;
    check_bit("R1 accepts full group", alloc_ready_o, 1'b1);
    clear_in();

    // R2 R7 R11: mixed classes in one group
    put_op(0, 0, C_LD, 0, 1, 0, 1, 8'd1);
    put_op(1, 0, C_LD, 0, 1, 0, 1, 8'd2);
    put_op(2, 0, C_STA, 0, 1, 0, 1, 8'd3);
    put_op(3, 0, C_STD, 0, 1, 0, 1, 8'd4);
    put_op(4, 0, C_PERM, 0, 1, 0, 1, 8'd5);
    tick();
    expect_disp(2, 1, 0); expect_disp(3, 2, 0); expect_disp(7, 3, 0);
    expect_disp(4, 4, 0); expect_disp(5, 5, 0);
    check_disp("R2 class steering");
    tick();
    check_disp("R7 granted entries freed");

    // R3 R5: two waiting divides, woken together
    put_op(0, 0, C_DIV, 7'd9, 0, 0, 1, 8'd10);
    tick(); check_disp("R3 held while waiting");
    put_op(0, 0, C_DIV, 7'd9, 0, 0, 1, 8'd11);
    tick(); check_disp("R3 held while waiting");
    bcast(0, 7'd8);
    tick(); check_disp("R4 unmatched tag wakes nothing");
    bcast(1, 7'd9);
    tick(); expect_disp(0, 10, 0); check_disp("R5 oldest first");
    tick(); expect_disp(0, 11, 0); check_disp("R5 younger next");
    tick(); check_disp("R5 drained");

    // R4 broadcast in the allocation cycle
    put_op(0, 0, C_DIV, 0, 1, 7'd33, 0, 8'd20);
    bcast(3, 7'd33);
    tick(); expect_disp(0, 20, 0); check_disp("R4 same-cycle wakeup");
    tick(); check_disp("R4 drained");

    // R6 R7: five integer ops, lower port first, slot order is age
    for (int s = 0; s < 5; s++) put_op(s, 0, C_INT, 0, 1, 0, 1, 8'(30 + s));
    tick();
    expect_disp(0, 30, 0); expect_disp(1, 31, 0); expect_disp(5, 32, 0); expect_disp(6, 33, 0);
    check_disp("R6 ascending port claim");
    tick(); expect_disp(0, 34, 0); check_disp("R7 fifth slot youngest");
    tick(); check_disp("R6 drained");

    // R11 all ten ports at once
    put_op(0, 0, C_INT, 7'd41, 0, 0, 1, 8'd50);
    put_op(1, 0, C_INT, 7'd41, 0, 0, 1, 8'd51);
    put_op(2, 0, C_INT, 7'd41, 0, 0, 1, 8'd52);
    put_op(3, 0, C_INT, 7'd41, 0, 0, 1, 8'd53);
    put_op(4, 0, C_LD, 7'd41, 0, 0, 1, 8'd54);
    tick(); check_disp("R11 waiting");
    put_op(0, 1, C_LD, 7'd41, 0, 0, 1, 8'd55);
    put_op(1, 1, C_STA, 7'd41, 0, 0, 1, 8'd56);
    put_op(2, 1, C_STA, 7'd41, 0, 0, 1, 8'd57);
    put_op(3, 1, C_STD, 7'd41, 0, 0, 1, 8'd58);
    put_op(4, 1, C_STD, 7'd41, 0, 0, 1, 8'd59);
    tick(); check_disp("R11 waiting");
    bcast(2, 7'd41);
    tick();
    expect_disp(0, 50, 0); expect_disp(1, 51, 0); expect_disp(5, 52, 0); expect_disp(6, 53, 0);
    expect_disp(2, 54, 0); expect_disp(3, 55, 1); expect_disp(7, 56, 1); expect_disp(8, 57, 1);
    expect_disp(4, 58, 1); expect_disp(9, 59, 1);
    check_disp("R11 ten grants");
    tick(); check_disp("R11 drained");

    // R9 per-thread flush
    put_op(0, 0, C_DIV, 7'd50, 0, 0, 1, 8'd60);
    put_op(1, 1, C_DIV, 7'd50, 0, 0, 1, 8'd61);
    tick(); check_disp("R9 waiting");
    flush_i[0] = 1'b1;
    put_op(0, 0, C_DIV, 0, 1, 0, 1, 8'd62);
    tick(); check_disp("R9 flushed-thread slot dropped");
    bcast(0, 7'd50);
    tick(); expect_disp(0, 61, 1); check_disp("R9 other thread survives");
    tick(); check_disp("R9 drained");

    // R8 R10: thread 1 fills the pool
    for (int g = 0; g < 6; g++) begin
      for (int s = 0; s < 5; s++) put_op(s, 1, C_DIV, 7'd60, 0, 0, 1, 8'(100 + g*5 + s));
      tick();
    end
    check_disp("R10 fill waiting");
    for (int s = 0; s < 3; s++) put_op(s, 0, C_DIV, 0, 1, 0, 1, 8'(200 + s));
    #1; check_bit("R8 stall when one short", alloc_ready_o, 1'b0);
    tick(); check_disp("R8 stalled group not written");
    put_op(0, 1, C_DIV, 7'd60, 0, 0, 1, 8'd130);
    put_op(1, 1, C_DIV, 7'd60, 0, 0, 1, 8'd131);
    #1; check_bit("R8 exact fit accepted", alloc_ready_o, 1'b1);
    tick(); check_disp("R10 fill waiting");
    put_op(0, 0, C_DIV, 0, 1, 0, 1, 8'd203);
    #1; check_bit("R10 one thread holds all entries", alloc_ready_o, 1'b0);
    tick(); check_disp("R10 full pool rejects");
    bcast(0, 7'd60);
    tick(); expect_disp(0, 100, 1); check_disp("R5 oldest of full pool");
    flush_i[1] = 1'b1; #1;
    check_disp("R9 no grant during flush");
    tick(); check_disp("R9 flushed");
    for (int s = 0; s < 5; s++) put_op(s, 0, C_INT, 0, 1, 0, 1, 8'(140 + s));
    #1; check_bit("R9 flush frees entries", alloc_ready_o, 1'b1);
    tick();
    expect_disp(0, 140, 0); expect_disp(1, 141, 0); expect_disp(5, 142, 0); expect_disp(6, 143, 0);
    check_disp("R9 pool usable after flush");
    tick(); expect_disp(0, 144, 0); check_disp("R9 pool usable after flush");
    tick(); check_disp("R1 empty at end");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule